// File: doc/BRIEF.md
# Free-Running Timer with Two Compare Outputs

This block is a 16-bit up-counter that advances once per tick from a selectable source. The source is one of three internal enable strobes or an external tick pin. Two compare channels watch the counter. When the counter steps onto a channel's compare value, the channel's output pin takes that channel's programmed level, and a sticky match flag is raised.

Channel A can also restart the counter. This turns the free-running count into a periodic one with a period of compare A plus one ticks. All settings are loaded through a small write port with a two-bit address:

| Address | Register | Fields |
|---|---|---|
| 0 | Compare A | the compare value |
| 1 | Compare B | the compare value |
| 2 | Control | bit 0 level A, bit 1 level B, bit 2 clear-on-A, bits 4:3 tick source |
| 3 | Flag clear | a 0 in bit 0 clears flag A, a 0 in bit 1 clears flag B, a 1 leaves the flag unchanged |

Top module: `frt_ocmp`

## Requirements
- R1: While reset is high and on the first cycle after it, the count, both compare outputs and both match flags are 0.
- R2: The count goes up by exactly one on each tick of the selected source and holds otherwise. Source code 0, 1 and 2 select `int_tick[0]`, `int_tick[1]` and `int_tick[2]`; code 3 selects the external tick. Strobes on unselected sources leave the count unchanged.
- R3: The external tick passes through two synchronising flip-flops followed by a rising-edge detector. A rising edge that is set up before clock edge k advances the count at edge k+2. A level held high for many cycles gives exactly one tick.
- R4: On the clock edge where the count steps onto a channel's compare value, that channel's output takes its level bit and its match flag becomes 1.
- R5: Writing a compare value equal to the count that is already held does not produce a match. Only a later step onto that value does.
- R6: Each compare output stays 0 until that channel's first match, whatever its level bit says.
- R7: With clear-on-A set, a tick that arrives while the count equals compare A loads 0 instead of counting up. With clear-on-A off, the count passes compare A.
- R8: With clear-on-A off, the count wraps from 0xFFFF to 0. With clear-on-A on and compare A at 0xFFFF, the clear and the wrap coincide and the count goes to 0.
- R9: A match flag stays set until a write to address 3 carries a 0 in its bit. A 1 has no effect. A match in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 cmp A, 1 cmp B, 2 control, 3 flag clear) |
| wr_data | input | 16 | Write data |
| int_tick | input | 3 | Internal tick enable strobes |
| ext_tick | input | 1 | Asynchronous external tick |
| cnt_o | output | 16 | Current count |
| cmp_out | output | 2 | Compare outputs, bit 0 channel A, bit 1 channel B |
| match_flag | output | 2 | Sticky match flags, bit 0 channel A, bit 1 channel B |

## Verification
Two pairs of events can land on the same cycle, and the bench forces each pair to coincide on purpose.

The first pair is a channel match and a software write that clears the same channel's flag. The bench aims compare B one step ahead of the count, then issues the clearing write together with the tick. It expects the flag to remain set.

The second pair is the clear on channel A and the counter's natural wrap. The bench sets compare A to 0xFFFF and runs the count up to it. It then judges the next tick by a zero count and by match A firing on no step other than the one onto 0xFFFF.

Constrained-random traffic with a short channel A period keeps matches, clears and flag writes overlapping throughout the run. A reference model checks the outputs every cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int CNT_W = 16;
    localparam int N_INT = 3;
    localparam int N_CH  = 2;

    typedef enum logic [1:0] {
        SRC_INT0 = 2'd0,
        SRC_INT1 = 2'd1,
        SRC_INT2 = 2'd2,
        SRC_EXT  = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        ADDR_CMPA = 2'd0,
        ADDR_CMPB = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_FLAG = 2'd3
    } reg_addr_e;

    // control word: src in [4:3], clear-on-A in [2], levels in [1:0]
    typedef struct packed {
        tick_src_e        src;
        logic             clr_on_a;
        logic [N_CH-1:0]  lvl;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [CNT_W-1:0] step_count(
        input logic [CNT_W-1:0] cur,
        input logic             restart
    );
        return restart ? '0 : cur + 1'b1;
    endfunction

endpackage

// File: rtl/frt_tick_sel.sv
module frt_tick_sel
    import frt_pkg::*;
#(
    parameter int N_SRC  = N_INT,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_src_e        src,
    input  logic [N_SRC-1:0] int_tick,
    input  logic             ext_tick,
    output logic             tick
);
    localparam int CHAIN = SYNC_N + 1;

    logic [CHAIN-1:0] chain_q;
    logic             ext_rise;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN-2:0], ext_tick};
    end

    assign ext_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    always_comb begin
        tick = 1'b0;
        if (src == SRC_EXT) begin
            tick = ext_rise;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (int'(src) == i) tick = int_tick[i];
            end
        end
    end

endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr_en,
    input  logic [W-1:0] clr_at,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx
);
    logic restart;

    assign restart = clr_en && (cnt_q == clr_at);
    assign cnt_nx  = step_count(cnt_q, restart);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/frt_ocmp_ch.sv
module frt_ocmp_ch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] cnt_nx,
    input  logic [W-1:0] cmp,
    input  logic         lvl,
    input  logic         flag_clr,
    output logic         pin_q,
    output logic         flag_q
);
    logic hit;

    assign hit = adv && (cnt_nx == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (hit) pin_q <= lvl;
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/frt_ocmp.sv
module frt_ocmp
    import frt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [N_INT-1:0] int_tick,
    input  logic             ext_tick,
    output logic [W-1:0]     cnt_o,
    output logic [N_CH-1:0]  cmp_out,
    output logic [N_CH-1:0]  match_flag
);
    ctrl_t           ctrl_q;
    logic [W-1:0]    cmp_q [N_CH];
    logic            tick;
    logic [W-1:0]    cnt_nx;
    logic [N_CH-1:0] flag_clr;
    reg_addr_e       addr;

    assign addr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int i = 0; i < N_CH; i++) cmp_q[i] <= '1;
        end else if (wr_en) begin
            case (addr)
                ADDR_CMPA: cmp_q[0] <= wr_data;
                ADDR_CMPB: cmp_q[1] <= wr_data;
                ADDR_CTRL: ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    assign flag_clr = (wr_en && addr == ADDR_FLAG) ? ~wr_data[N_CH-1:0] : '0;

    frt_tick_sel #(.N_SRC(N_INT), .SYNC_N(2)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (ctrl_q.src),
        .int_tick (int_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    frt_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .clr_en (ctrl_q.clr_on_a),
        .clr_at (cmp_q[0]),
        .cnt_q  (cnt_o),
        .cnt_nx (cnt_nx)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        frt_ocmp_ch #(.W(W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .adv      (tick),
            .cnt_nx   (cnt_nx),
            .cmp      (cmp_q[c]),
            .lvl      (ctrl_q.lvl[c]),
            .flag_clr (flag_clr[c]),
            .pin_q    (cmp_out[c]),
            .flag_q   (match_flag[c])
        );
    end

endmodule

// File: rtl/frt_ocmp_chk.sv
module frt_ocmp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] cnt_o,
    input logic [1:0]   cmp_out,
    input logic [1:0]   match_flag
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> (cnt_o == '0 && cmp_out == 2'b00 && match_flag == 2'b00));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

    // R6
    out_a_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_out[0]) |-> match_flag[0]);

    // R6
    out_b_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_out[1]) |-> match_flag[1]);

    // R9
    flag_a_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(match_flag[0]) |-> $past(wr_en && wr_addr == 2'd3 && !wr_data[0]));

    // R9
    flag_b_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(match_flag[1]) |-> $past(wr_en && wr_addr == 2'd3 && !wr_data[1]));

endmodule

bind frt_ocmp frt_ocmp_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cnt_o      (cnt_o),
    .cmp_out    (cmp_out),
    .match_flag (match_flag)
);

// File: tb/frt_ocmp_tb.sv
module frt_ocmp_tb;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [2:0]    int_tick = '0;
    logic          ext_tick = 1'b0;
    logic [W-1:0]  cnt_o;
    logic [1:0]    cmp_out;
    logic [1:0]    match_flag;

    int n_chk = 0;
    int n_err = 0;
    string tag = "R1";

    // reference model state
    logic [W-1:0] m_cnt, m_cmpa, m_cmpb;
    logic [4:0]   m_ctrl;
    logic [1:0]   m_out, m_flag;
    logic [2:0]   m_sync;

    always #2 clk = ~clk;

    frt_ocmp u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .int_tick(int_tick), .ext_tick(ext_tick),
        .cnt_o(cnt_o), .cmp_out(cmp_out), .match_flag(match_flag)
    );

    function automatic logic [W-1:0] nxt(input logic [W-1:0] c, input logic clr,
                                         input logic [W-1:0] ca);
        return (clr && c == ca) ? '0 : c + 1'b1;
    endfunction

    always @(posedge clk) begin
        logic tk, rise;
        logic [W-1:0] nx;
        logic [1:0] hit, clr;
        if (rst) begin
            m_cnt = '0; m_cmpa = '1; m_cmpb = '1; m_ctrl = '0;
            m_out = '0; m_flag = '0; m_sync = '0;
        end else begin
            rise   = m_sync[1] & ~m_sync[2];
            m_sync = {m_sync[1:0], ext_tick};
            tk     = (m_ctrl[4:3] == 2'd3) ? rise : int_tick[m_ctrl[4:3]];
            nx     = nxt(m_cnt, m_ctrl[2], m_cmpa);
            hit    = tk ? {nx == m_cmpb, nx == m_cmpa} : 2'b00;
            clr    = (wr_en && wr_addr == 2'd3) ? ~wr_data[1:0] : 2'b00;
            for (int c = 0; c < 2; c++) begin
                if (hit[c]) begin
                    m_out[c] = m_ctrl[c];
                    m_flag[c] = 1'b1;
                end else if (clr[c]) begin
                    m_flag[c] = 1'b0;
                end
            end
            if (tk) m_cnt = nx;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_cmpa = wr_data;
                    2'd1: m_cmpb = wr_data;
                    2'd2: m_ctrl = wr_data[4:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk({tag, " count"}, cnt_o, m_cnt);
        chk({tag, " outputs"}, W'(cmp_out), W'(m_out));
        chk({tag, " flags"}, W'(match_flag), W'(m_flag));
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input logic [2:0] m);
        int_tick = m;
        repeat (n) step();
        int_tick = '0;
    endtask

    initial begin
        logic [W-1:0] base;
        void'($urandom(32'd7001));
        repeat (3) step();
        chk("R1 reset count", cnt_o, '0);
        chk("R1 reset flags", W'(match_flag), '0);
        rst = 1'b0;
        step();
        chk("R1 after release", W'(cmp_out), '0);

        tag = "R6";
        wr(2'd2, 16'h0003);
        wr(2'd0, 16'd100);
        wr(2'd1, 16'd200);
        ticks(50, 3'b001);
        chk("R6 outputs low before match", W'(cmp_out), '0);

        tag = "R4";
        ticks(60, 3'b001);
        chk("R4 out A at level 1", W'(cmp_out[0]), 16'd1);
        chk("R4 flag A set", W'(match_flag[0]), 16'd1);

        tag = "R5";
        wr(2'd1, cnt_o);
        repeat (5) step();
        chk("R5 flag B not set by held value", W'(match_flag[1]), '0);

        tag = "R9";
        wr(2'd3, 16'h0002);
        chk("R9 flag A cleared by 0", W'(match_flag[0]), '0);
        wr(2'd1, cnt_o + 1'b1);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = '0; int_tick = 3'b001;
        step();
        wr_en = 1'b0; int_tick = '0;
        chk("R9 set wins over clear", W'(match_flag[1]), 16'd1);
        wr(2'd3, 16'h0001);
        chk("R9 bit of 1 keeps flag A", W'(match_flag[0]), '0);
        chk("R9 flag B cleared", W'(match_flag[1]), '0);

        tag = "R7";
        wr(2'd2, 16'h0004);
        wr(2'd0, cnt_o + 16'd5);
        ticks(6, 3'b001);
        chk("R7 cleared after compare A", cnt_o, '0);
        ticks(3, 3'b001);
        chk("R7 counts after clear", cnt_o, 16'd3);

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 19);
            if (r == 0)      wr(2'd2, W'($urandom_range(0, 31)));
            else if (r == 1) wr(2'd0, W'($urandom_range(0, 40)));
            else if (r == 2) wr(2'd1, W'($urandom_range(0, 40)));
            else if (r == 3) wr(2'd3, W'($urandom_range(0, 3)));
            else begin
                int_tick = 3'($urandom());
                ext_tick = 1'($urandom());
                step();
            end
        end
        int_tick = '0; ext_tick = 1'b0;

        tag = "R3";
        wr(2'd2, 16'h0018);
        repeat (4) step();
        base = cnt_o;
        ext_tick = 1'b1;
        step();
        step();
        chk("R3 no tick yet", cnt_o, base);
        step();
        chk("R3 tick after sync", cnt_o, base + 1'b1);
        int_tick = 3'b111;
        repeat (10) step();
        int_tick = '0;
        chk("R3 held level one tick", cnt_o, base + 1'b1);
        ext_tick = 1'b0;

        tag = "R8";
        wr(2'd2, 16'h0000);
        base = cnt_o;
        ticks(65536, 3'b001);
        chk("R8 full wrap returns", cnt_o, base);
        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'h0004);
        wr(2'd3, 16'h0000);
        ticks(int'(16'hFFFF - cnt_o), 3'b001);
        chk("R8 at top", cnt_o, 16'hFFFF);
        ticks(1, 3'b001);
        chk("R8 clear with wrap", cnt_o, '0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule